// File: doc/BRIEF.md
# Data ALU Status Flag Register

This block keeps the eight status flags that describe the outcome of arithmetic in a DSP's data ALU. Each time the ALU presents a finished result, six flags are recomputed from that cycle's result word, carry-out and overflow indication. These six describe the result's sign, whether it is zero, whether it uses the guard (extension) bits, whether it is normalized, and its overflow and carry. Each new result replaces all six.

Two further flags are sticky. The limit flag records that an ALU overflow happened, or that an accumulator value was saturated while it was being moved. The scaling flag records that an accumulator needs rescaling for block floating-point work. Once set, these two flags stay set until software writes the register.

Cycles with no ALU result leave every flag unchanged. Address arithmetic and plain bus transfers are such cycles. The flags are registered, so an update becomes visible one clock after the event that causes it.

Top module: `alu_status_flags`

## Requirements
- R1: While reset is asserted (rst_n low), and in the cycle after it is released, all eight flag bits read 0.
- R2: flags_o carries S (scaling) in bit 7, L (limit) in bit 6, E (extension) in bit 5, U (unnormalized) in bit 4, N (negative) in bit 3, Z (zero) in bit 2, V (overflow) in bit 1 and C (carry) in bit 0. Every update appears on flags_o one clock after the inputs that cause it.
- R3: On a cycle with res_valid high, N becomes the most significant bit of res_data. Z becomes 1 exactly when every bit of res_data is 0.
- R4: On a cycle with res_valid high, E becomes 1 unless the top EXT_W+1 bits of res_data are all equal.
- R5: On a cycle with res_valid high, U becomes 1 when bit DATA_W-EXT_W-1 and bit DATA_W-EXT_W-2 of res_data are equal.
- R6: On a cycle with res_valid high, V becomes res_ovf and C becomes res_carry.
- R7: On a cycle with neither res_valid nor sw_we high, E, U, N, Z, V and C keep their values.
- R8: L is set by a valid result with res_ovf high, or by lim_evt. It is never cleared by a result or by a cycle without events.
- R9: S is set by scl_evt. It is never cleared by a result or by a cycle without events.
- R10: sw_we loads sw_wdata into all eight flags, using the bit order of R2. In the same cycle, a set event for L or S takes priority over the written 0 for that flag. A valid result takes priority over the written values of the six non-sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | An ALU result is present this cycle |
| res_data | input | DATA_W | ALU result word |
| res_carry | input | 1 | Carry or borrow out of the result MSB |
| res_ovf | input | 1 | Arithmetic overflow of the result |
| lim_evt | input | 1 | Accumulator value was saturated during a move |
| scl_evt | input | 1 | Accumulator needs scaling |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write value |
| flags_o | output | 8 | Registered flags, bit order per R2 |

## Verification
The bench builds the block with DATA_W=12 and EXT_W=4. With those values the extension window is bits 11 to 7 and the normalization pair is bits 7 and 6. That makes every one of the 4096 result words reachable in a full sweep. Each word is paired with a changing carry and overflow pattern, and the bench computes every flag arithmetically from the word. The sweep is interleaved with idle cycles and with colliding software writes and set events. This exercises the sticky and priority rules on every edge of the word space.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
    // Positions within the 8-bit flag word
    localparam int FLG_S = 7;
    localparam int FLG_L = 6;
    localparam int FLG_E = 5;
    localparam int FLG_U = 4;
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
    localparam int NUM_STICKY = 2;

    typedef struct packed {
        logic ext;
        logic unnorm;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } live_flags_t;
endpackage

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
    parameter int DATA_W = 56,
    parameter int EXT_W  = 8
) (
    input  logic [DATA_W-1:0]       res_data,
    input  logic                    res_carry,
    input  logic                    res_ovf,
    output alu_flag_pkg::live_flags_t fresh
);
    localparam int GUARD_N = EXT_W + 1;
    localparam int NORM_HI = DATA_W - EXT_W - 1;

    logic [GUARD_N-1:0] guard;

    always_comb begin
        guard        = res_data[DATA_W-1 -: GUARD_N];
        fresh.ext    = !((&guard) || !(|guard));
        fresh.unnorm = res_data[NORM_HI] ~^ res_data[NORM_HI-1];
        fresh.neg    = res_data[DATA_W-1];
        fresh.zero   = !(|res_data);
        fresh.ovf    = res_ovf;
        fresh.carry  = res_carry;
    end
endmodule

// File: rtl/alu_flag_sticky.sv
module alu_flag_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_en_i,
    input  logic wr_val_i,
    output logic bit_o
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q;
        if (wr_en_i) bit_d = wr_val_i;
        if (set_i)   bit_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign bit_o = bit_q;

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !wr_en_i) |=> bit_q);
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> bit_q);
endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags #(
    parameter int DATA_W = 56,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_carry,
    input  logic              res_ovf,
    input  logic              lim_evt,
    input  logic              scl_evt,
    input  logic              sw_we,
    input  logic [7:0]        sw_wdata,
    output logic [7:0]        flags_o
);
    import alu_flag_pkg::*;

    live_flags_t fresh;
    live_flags_t live_d, live_q;
    logic [NUM_STICKY-1:0] stk_set, stk_wval, stk_q;

    alu_flag_eval #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_eval (
        .res_data (res_data),
        .res_carry(res_carry),
        .res_ovf  (res_ovf),
        .fresh    (fresh)
    );

    always_comb begin
        live_d = live_q;
        if (sw_we) live_d = live_flags_t'(sw_wdata[FLG_E:FLG_C]);
        if (res_valid) live_d = fresh;
        // index 1 = L, index 0 = S
        stk_set[1]  = (res_valid && res_ovf) || lim_evt;
        stk_set[0]  = scl_evt;
        stk_wval[1] = sw_wdata[FLG_L];
        stk_wval[0] = sw_wdata[FLG_S];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
        alu_flag_sticky u_stk (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (stk_set[i]),
            .wr_en_i (sw_we),
            .wr_val_i(stk_wval[i]),
            .bit_o   (stk_q[i])
        );
    end

    assign flags_o = {stk_q[0], stk_q[1], live_q};

    // R7
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !sw_we) |=> $stable(flags_o[FLG_E:FLG_C]));
    // R6
    ovf_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (flags_o[FLG_V] == $past(res_ovf)) && (flags_o[FLG_C] == $past(res_carry)));
    // R3
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FLG_Z] |-> !flags_o[FLG_N] || !$past(res_valid));
    // R8
    lim_from_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ovf) |=> flags_o[FLG_L]);
    // R9
    scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[FLG_S] && !sw_we) |=> flags_o[FLG_S]);
endmodule

// File: tb/sim_alu_status_flags.sv
`timescale 1ns/1ps
module sim_alu_status_flags;
    localparam int DW = 12;
    localparam int EW = 4;

    logic clk = 0, rst_n = 0;
    logic res_valid = 0, res_carry = 0, res_ovf = 0;
    logic [DW-1:0] res_data = '0;
    logic lim_evt = 0, scl_evt = 0, sw_we = 0;
    logic [7:0] sw_wdata = '0;
    logic [7:0] flags_o;

    int checks = 0, failures = 0;
    logic [7:0] exp_f = 8'h00;
    bit done = 0;

    always #2 clk = ~clk;

    alu_status_flags #(.DATA_W(DW), .EXT_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_carry(res_carry), .res_ovf(res_ovf), .lim_evt(lim_evt),
        .scl_evt(scl_evt), .sw_we(sw_we), .sw_wdata(sw_wdata), .flags_o(flags_o)
    );

    task automatic check(input string req);
        checks++;
        if (flags_o !== exp_f) begin
            failures++;
            $display("FAIL %s: flags=%02h expected=%02h", req, flags_o, exp_f);
        end
    endtask

    // Reference: six live flags from a result word, computed arithmetically
    function automatic logic [5:0] ref_live(input int v, input bit cy, input bit ov);
        int top;
        bit e, u, n, z;
        top = v / 128;              // bits 11..7
        e = !(top == 0 || top == 31);
        u = ((v / 128) % 2) == ((v / 64) % 2);
        n = v >= 2048;
        z = v == 0;
        return {e, u, n, z, ov, cy};
    endfunction

    // Drive at negedge, step one clock, sample at following negedge
    task automatic step(input bit rv, input int v, input bit cy, input bit ov,
                        input bit le, input bit se, input bit we, input logic [7:0] wd);
        res_valid = rv; res_data = DW'(v); res_carry = cy; res_ovf = ov;
        lim_evt = le; scl_evt = se; sw_we = we; sw_wdata = wd;
        if (we) exp_f = wd;
        if (rv) exp_f[5:0] = ref_live(v, cy, ov);
        if ((rv && ov) || le) exp_f[6] = 1'b1;
        if (se) exp_f[7] = 1'b1;
        @(negedge clk);
        res_valid = 0; lim_evt = 0; scl_evt = 0; sw_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1;
        @(negedge clk);
        check("R1 after release");

        // Exhaustive sweep of result words, R2 R3 R4 R5 R6 R8
        for (int v = 0; v < 4096; v++) begin
            bit cy, ov;
            cy = v[0] ^ v[5];
            ov = (v % 97) == 3;
            step(1, v, cy, ov, 0, 0, 0, 8'h00);
            check("R3/R4/R5/R6 sweep (R2 order, R8 sticky)");
            if (v % 512 == 7) begin
                // idle cycle: everything holds, R7
                step(0, 4095 - v, 1, 1, 0, 0, 0, 8'h00);
                check("R7 idle hold");
            end
            if (v % 1024 == 100) begin
                step(0, 0, 0, 0, 0, 0, 1, 8'h00);
                check("R10 write clears all");
            end
        end

        // R8 limit event sets and sticks
        step(0, 0, 0, 0, 1, 0, 0, 8'h00); check("R8 lim_evt sets L");
        step(1, 5, 0, 0, 0, 0, 0, 8'h00); check("R8 L survives result");
        step(0, 0, 0, 0, 0, 0, 0, 8'h00); check("R8 L survives idle");
        // R9 scaling
        step(0, 0, 0, 0, 0, 1, 0, 8'h00); check("R9 scl_evt sets S");
        step(1, 0, 1, 0, 0, 0, 0, 8'h00); check("R9 S survives result");
        // R10 priorities
        step(0, 0, 0, 0, 1, 1, 1, 8'h00); check("R10 set beats write 0");
        step(0, 0, 0, 0, 0, 0, 1, 8'h3F);
        if (exp_f !== 8'h3F) failures++;
        check("R10 write pattern R2 positions");
        step(1, 2048, 1, 0, 0, 0, 1, 8'hC0); check("R10 result beats write for live bits");
        step(0, 0, 0, 0, 0, 0, 1, 8'h15); check("R10 write odd pattern");
        step(1, 'h3C0, 0, 1, 0, 0, 0, 8'h00); check("R8 ovf result sets L");
        // R1 reset again
        rst_n = 0; @(negedge clk); exp_f = 8'h00; check("R1 re-reset");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (100000) @(posedge clk); failures++; checks++;
                  $display("FAIL watchdog: actual=timeout expected=done"); end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule